// File: doc/BRIEF.md
# SD Card SPI-Mode Single Block Data Mover

This block moves one data block between a local byte stream and an SD card that runs in SPI mode. It starts once the read or write command has already been accepted by the card. Each byte on the serial link goes through a byte-exchange handshake: the engine offers one byte to send, and the serial shifter returns the byte it received at the same time. The engine also drives the card's chip select, which is active low.

On a read, the engine sends idle bytes (0xFF) until the card returns the start token 0xFE. It then passes the payload bytes to the read stream in order and throws away the two CRC bytes. On a write, the engine sends 0xFE, then the payload taken from the write stream, then two 0xFF bytes where the CRC would go. It then reads the card's data response token. If the card accepts the block, the engine keeps polling while the card holds the line low (busy). Both waits have bounded timeouts. Every transfer ends with chip select high and one trailing idle byte, followed by a one-cycle done pulse that carries a failure flag and an error code.

The payload length is a parameter. A short register block, such as a 16-byte card descriptor, can therefore use the same read path as a full 512-byte sector.

Top module: `sd_block_mover`

## Requirements
- R1: While reset is held and just after it, csN is 1, spiReq is 0, done is 0, rdValid is 0 and wrReady is 0.
- R2: On a read (start with dirWrite=0), every exchange sends 0xFF. Received bytes other than 0xFE are discarded. A 0xFE received on the HUNT_LIMIT-th poll is still accepted as the start token.
- R3: After the start token, the next PAYLOAD_LEN received bytes come out on rdData/rdValid in order. No byte is lost or overwritten while rdReady is held low.
- R4: After the payload, two more 0xFF exchanges fetch the CRC bytes. Neither byte appears on the read stream.
- R5: On a write (start with dirWrite=1), the engine sends 0xFE, then the PAYLOAD_LEN bytes accepted on wrData/wrValid/wrReady in order, then two 0xFF bytes.
- R6: After the write CRC, one 0xFF exchange reads the response token and the engine looks at its low five bits. 0x05 means accepted. 0x0B ends the transfer with errCode 1 (CRC reject). Any other value ends it with errCode 2 (write reject). A rejected write does no busy polling.
- R7: After an accepted write, the engine sends 0xFF while the card returns 0x00 and stops at the first non-zero byte. If BUSY_LIMIT consecutive 0x00 bytes arrive, the transfer ends with errCode 3 (timeout).
- R8: If the first HUNT_LIMIT read polls bring no 0xFE, the read ends with errCode 3. No byte is delivered and no further poll is made with chip select low.
- R9: csN is 0 for every exchange of the transfer proper. The final exchange of every transfer is a single 0xFF sent with csN at 1, and done follows it.
- R10: done is a one-cycle pulse. fail equals done AND (errCode != 0). errCode keeps its value until the next accepted start (0 means success).
- R11: A start pulse while a transfer is in progress is ignored. The ongoing byte sequence is unchanged and only one done is produced.
- R12: Once spiReq is raised, it and spiTxByte stay stable until a cycle with spiAck high, which completes the exchange and samples spiRxByte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a block transfer (taken only when idle) |
| dirWrite | input | 1 | Direction sampled with start: 1 write, 0 read |
| spiReq | output | 1 | Byte exchange request to the serial shifter |
| spiTxByte | output | 8 | Byte to shift out |
| spiAck | input | 1 | Exchange complete, spiRxByte valid |
| spiRxByte | input | 8 | Byte shifted in |
| csN | output | 1 | Card chip select, active low |
| wrValid | input | 1 | Write stream byte valid |
| wrData | input | 8 | Write stream byte |
| wrReady | output | 1 | Write stream byte taken |
| rdValid | output | 1 | Read stream byte valid |
| rdData | output | 8 | Read stream byte |
| rdReady | input | 1 | Read stream consumer ready |
| done | output | 1 | One-cycle end-of-transfer pulse |
| fail | output | 1 | With done: transfer failed |
| errCode | output | 2 | 0 ok, 1 CRC reject, 2 write reject, 3 timeout |

## Verification
If the byte or poll counter is wrong, the exchange count is off by one somewhere. That shows up as one byte too many or too few on the serial side and as a misplaced chip-select rise, so every transfer is checked by its full exchange log. A framing state that goes astray shows up at once, in the next exchange, as a wrong transmitted byte (0xFE or data where 0xFF belongs) or as a CRC byte leaking into the read stream. The sweep over every response byte value and over the busy length up to and past the limit makes any wrong token mask or off-by-one timeout visible as a wrong errCode at the done pulse.

// File: rtl/sd_block_mover_pkg.sv
package sd_block_mover_pkg;

  localparam logic [7:0] START_TOKEN = 8'hFE;
  localparam logic [7:0] IDLE_BYTE   = 8'hFF;
  localparam logic [7:0] RESP_MASK   = 8'h1F;
  localparam logic [7:0] RESP_OK     = 8'h05;
  localparam logic [7:0] RESP_CRCBAD = 8'h0B;

  typedef enum logic [1:0] {
    TX_FF    = 2'd0,
    TX_START = 2'd1,
    TX_DATA  = 2'd2
  } txSel_e;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_CRC     = 2'd1,
    ERR_WRITE   = 2'd2,
    ERR_TIMEOUT = 2'd3
  } errCode_e;

  // control -> datapath strobes
  typedef struct packed {
    logic   issue;
    txSel_e txSel;
    logic   pushRd;
    logic   clrCnt;
    logic   incCnt;
    logic   clrTmo;
    logic   incTmo;
  } ctrlStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic       ack;
    logic [7:0] rxByte;
    logic       reqBusy;
    logic       rdFull;
    logic       cntLast;
    logic       cntCrcLast;
    logic       huntExpired;
    logic       busyExpired;
  } dpStatus_t;

endpackage

// File: rtl/sd_block_mover_dp.sv
module sd_block_mover_dp
  import sd_block_mover_pkg::*;
#(
  parameter int PAYLOAD_LEN = 512,
  parameter int HUNT_LIMIT  = 4096,
  parameter int BUSY_LIMIT  = 262144
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  output dpStatus_t   status,
  input  logic [7:0]  wrData,
  output logic        spiReq,
  output logic [7:0]  spiTxByte,
  input  logic        spiAck,
  input  logic [7:0]  spiRxByte,
  output logic        rdValid,
  output logic [7:0]  rdData,
  input  logic        rdReady
);

  localparam int CW     = (PAYLOAD_LEN > 2) ? $clog2(PAYLOAD_LEN) : 1;
  localparam int TMAX   = (HUNT_LIMIT > BUSY_LIMIT) ? HUNT_LIMIT : BUSY_LIMIT;
  localparam int TW     = $clog2(TMAX + 1);

  logic [CW-1:0] byteCnt;
  logic [TW-1:0] tmoCnt;
  logic [7:0]    txNext;

  always_comb begin
    case (strobe.txSel)
      TX_START: txNext = START_TOKEN;
      TX_DATA:  txNext = wrData;
      default:  txNext = IDLE_BYTE;
    endcase
  end

  // byte exchange request register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      spiReq    <= 1'b0;
      spiTxByte <= IDLE_BYTE;
    end else if (strobe.issue) begin
      spiReq    <= 1'b1;
      spiTxByte <= txNext;
    end else if (spiAck) begin
      spiReq    <= 1'b0;
    end
  end

  // read stream holding register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= 8'h00;
    end else if (strobe.pushRd) begin
      rdValid <= 1'b1;
      rdData  <= spiRxByte;
    end else if (rdValid && rdReady) begin
      rdValid <= 1'b0;
    end
  end

  // payload / CRC byte counter and poll counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteCnt <= '0;
      tmoCnt  <= '0;
    end else begin
      if (strobe.clrCnt)      byteCnt <= '0;
      else if (strobe.incCnt) byteCnt <= byteCnt + CW'(1);
      if (strobe.clrTmo)      tmoCnt  <= '0;
      else if (strobe.incTmo) tmoCnt  <= tmoCnt + TW'(1);
    end
  end

  assign status.ack         = spiReq && spiAck;
  assign status.rxByte      = spiRxByte;
  assign status.reqBusy     = spiReq;
  assign status.rdFull      = rdValid;
  assign status.cntLast     = (byteCnt == CW'(PAYLOAD_LEN - 1));
  assign status.cntCrcLast  = (byteCnt == CW'(1));
  assign status.huntExpired = (tmoCnt == TW'(HUNT_LIMIT - 1));
  assign status.busyExpired = (tmoCnt == TW'(BUSY_LIMIT - 1));

  // R12: request and byte held until acknowledged
  a_r12_req_hold : assert property (@(posedge clk) disable iff (!rstN)
    (spiReq && !spiAck) |=> (spiReq && $stable(spiTxByte)));

  // R3: a held read byte is neither dropped nor changed
  a_r3_rd_hold : assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdReady) |=> (rdValid && $stable(rdData)));

  // R3: control never pushes over an undelivered byte
  a_r3_no_overwrite : assert property (@(posedge clk) disable iff (!rstN)
    strobe.pushRd |-> !rdValid);

endmodule

// File: rtl/sd_block_mover_ctrl.sv
module sd_block_mover_ctrl
  import sd_block_mover_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        dirWrite,
  input  logic        wrValid,
  output logic        wrReady,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        csN,
  output logic        done,
  output logic        fail,
  output logic [1:0]  errCode
);

  typedef enum logic [3:0] {
    S_IDLE, S_HUNT, S_RDDATA, S_RDCRC,
    S_WRTOK, S_WRDATA, S_WRCRC, S_WRRESP, S_WRBUSY,
    S_TAIL, S_FIN
  } state_e;

  state_e   state, stateNext;
  errCode_e errReg, errNext;
  logic [7:0] respMasked;

  assign respMasked = status.rxByte & RESP_MASK;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    errNext   = errReg;
    done      = 1'b0;
    wrReady   = 1'b0;
    case (state)
      S_IDLE: begin
        if (start) begin
          strobe.clrCnt = 1'b1;
          strobe.clrTmo = 1'b1;
          errNext       = ERR_NONE;
          stateNext     = dirWrite ? S_WRTOK : S_HUNT;
        end
      end
      S_HUNT: begin
        strobe.issue = !status.reqBusy;
        if (status.ack) begin
          if (status.rxByte == START_TOKEN) begin
            strobe.clrCnt = 1'b1;
            stateNext     = S_RDDATA;
          end else if (status.huntExpired) begin
            errNext   = ERR_TIMEOUT;
            stateNext = S_TAIL;
          end else begin
            strobe.incTmo = 1'b1;
          end
        end
      end
      S_RDDATA: begin
        strobe.issue = !status.reqBusy && !status.rdFull;
        if (status.ack) begin
          strobe.pushRd = 1'b1;
          if (status.cntLast) begin
            strobe.clrCnt = 1'b1;
            stateNext     = S_RDCRC;
          end else begin
            strobe.incCnt = 1'b1;
          end
        end
      end
      S_RDCRC: begin
        strobe.issue = !status.reqBusy;
        if (status.ack) begin
          if (status.cntCrcLast) stateNext = S_TAIL;
          else                   strobe.incCnt = 1'b1;
        end
      end
      S_WRTOK: begin
        strobe.issue = !status.reqBusy;
        strobe.txSel = TX_START;
        if (status.ack) stateNext = S_WRDATA;
      end
      S_WRDATA: begin
        wrReady      = !status.reqBusy;
        strobe.issue = wrValid && !status.reqBusy;
        strobe.txSel = TX_DATA;
        if (status.ack) begin
          if (status.cntLast) begin
            strobe.clrCnt = 1'b1;
            stateNext     = S_WRCRC;
          end else begin
            strobe.incCnt = 1'b1;
          end
        end
      end
      S_WRCRC: begin
        strobe.issue = !status.reqBusy;
        if (status.ack) begin
          if (status.cntCrcLast) stateNext = S_WRRESP;
          else                   strobe.incCnt = 1'b1;
        end
      end
      S_WRRESP: begin
        strobe.issue = !status.reqBusy;
        if (status.ack) begin
          if (respMasked == RESP_OK) begin
            strobe.clrTmo = 1'b1;
            stateNext     = S_WRBUSY;
          end else begin
            errNext   = (respMasked == RESP_CRCBAD) ? ERR_CRC : ERR_WRITE;
            stateNext = S_TAIL;
          end
        end
      end
      S_WRBUSY: begin
        strobe.issue = !status.reqBusy;
        if (status.ack) begin
          if (status.rxByte != 8'h00) begin
            stateNext = S_TAIL;
          end else if (status.busyExpired) begin
            errNext   = ERR_TIMEOUT;
            stateNext = S_TAIL;
          end else begin
            strobe.incTmo = 1'b1;
          end
        end
      end
      S_TAIL: begin
        strobe.issue = !status.reqBusy;
        if (status.ack) stateNext = S_FIN;
      end
      S_FIN: begin
        if (!status.rdFull) begin
          done      = 1'b1;
          stateNext = S_IDLE;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      errReg <= ERR_NONE;
    end else begin
      state  <= stateNext;
      errReg <= errNext;
    end
  end

  assign csN     = (state == S_IDLE) || (state == S_TAIL) || (state == S_FIN);
  assign fail    = done && (errReg != ERR_NONE);
  assign errCode = errReg;

  // R10: done lasts one cycle
  a_r10_done_pulse : assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: chip select already released when done is reported
  a_r9_cs_at_done : assert property (@(posedge clk) disable iff (!rstN)
    done |-> csN);

  // R7: busy polling only follows an accepted response
  a_r7_busy_clean : assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WRBUSY) |-> (errReg == ERR_NONE));

  // R11: a start during a transfer does not restart the read hunt
  a_r11_no_restart : assert property (@(posedge clk) disable iff (!rstN)
    (start && state != S_IDLE && state != S_HUNT) |=> (state != S_HUNT));

endmodule

// File: rtl/sd_block_mover.sv
module sd_block_mover #(
  parameter int PAYLOAD_LEN = 512,
  parameter int HUNT_LIMIT  = 4096,
  parameter int BUSY_LIMIT  = 262144
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       dirWrite,
  output logic       spiReq,
  output logic [7:0] spiTxByte,
  input  logic       spiAck,
  input  logic [7:0] spiRxByte,
  output logic       csN,
  input  logic       wrValid,
  input  logic [7:0] wrData,
  output logic       wrReady,
  output logic       rdValid,
  output logic [7:0] rdData,
  input  logic       rdReady,
  output logic       done,
  output logic       fail,
  output logic [1:0] errCode
);

  sd_block_mover_pkg::ctrlStrobe_t strobe;
  sd_block_mover_pkg::dpStatus_t   status;

  sd_block_mover_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .dirWrite (dirWrite),
    .wrValid  (wrValid),
    .wrReady  (wrReady),
    .status   (status),
    .strobe   (strobe),
    .csN      (csN),
    .done     (done),
    .fail     (fail),
    .errCode  (errCode)
  );

  sd_block_mover_dp #(
    .PAYLOAD_LEN (PAYLOAD_LEN),
    .HUNT_LIMIT  (HUNT_LIMIT),
    .BUSY_LIMIT  (BUSY_LIMIT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .status    (status),
    .wrData    (wrData),
    .spiReq    (spiReq),
    .spiTxByte (spiTxByte),
    .spiAck    (spiAck),
    .spiRxByte (spiRxByte),
    .rdValid   (rdValid),
    .rdData    (rdData),
    .rdReady   (rdReady)
  );

endmodule

// File: tb/sd_block_mover_tb.sv
module sd_block_mover_tb;

  localparam int PL = 4;
  localparam int HL = 6;
  localparam int BL = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, dirWrite = 1'b0;
  logic spiReq, spiAck = 1'b0;
  logic [7:0] spiTxByte, spiRxByte = 8'hFF;
  logic csN;
  logic wrValid = 1'b0, wrReady;
  logic [7:0] wrData = 8'h00;
  logic rdValid, rdReady = 1'b0;
  logic [7:0] rdData;
  logic done, fail;
  logic [1:0] errCode;

  always #4 clk = ~clk;

  sd_block_mover #(.PAYLOAD_LEN(PL), .HUNT_LIMIT(HL), .BUSY_LIMIT(BL)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .dirWrite(dirWrite),
    .spiReq(spiReq), .spiTxByte(spiTxByte), .spiAck(spiAck), .spiRxByte(spiRxByte),
    .csN(csN), .wrValid(wrValid), .wrData(wrData), .wrReady(wrReady),
    .rdValid(rdValid), .rdData(rdData), .rdReady(rdReady),
    .done(done), .fail(fail), .errCode(errCode)
  );

  int checks = 0, errors = 0, cyc = 0;
  logic [7:0] rxScript [64];
  logic [7:0] exTx [64];
  logic       exCs [64];
  int exIdx = 0;
  logic [7:0] rdLog [16];
  int rdCnt = 0, wrIdx = 0, wrSeed = 0, doneCnt = 0;
  bit wrEn = 1'b0;
  bit lastFail = 1'b0;
  logic [1:0] lastCode = 2'd0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] wrPat(int seed, int i);
    return 8'((seed * 37 + i * 11 + 5) & 255);
  endfunction

  function automatic logic [7:0] rdPat(int k, int i);
    return 8'((k * 29 + i * 13 + 1) & 255);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // card model behind the byte-exchange handshake
  initial forever begin
    @(negedge clk);
    if (spiReq) begin
      repeat (exIdx % 3) @(negedge clk);
      exTx[exIdx % 64] = spiTxByte;
      exCs[exIdx % 64] = csN;
      spiRxByte = rxScript[exIdx % 64];
      spiAck = 1'b1;
      exIdx++;
      @(negedge clk);
      spiAck = 1'b0;
    end
  end

  // read stream consumer with stalls
  initial forever begin
    @(negedge clk);
    rdReady = ((cyc % 4) != 2);
    #1;
    if (rdValid && rdReady) begin
      rdLog[rdCnt % 16] = rdData;
      rdCnt++;
    end
  end

  // write stream producer with gaps
  initial forever begin
    @(negedge clk);
    wrValid = wrEn && (wrIdx < PL) && ((cyc % 5) != 3);
    wrData  = wrPat(wrSeed, wrIdx);
    #1;
    if (wrValid && wrReady) wrIdx++;
  end

  // done monitor
  initial forever begin
    @(negedge clk);
    if (done) begin
      doneCnt++;
      lastFail = fail;
      lastCode = errCode;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic runXfer(bit isWrite);
    int d0;
    exIdx = 0; rdCnt = 0; wrIdx = 0;
    wrEn = isWrite;
    d0 = doneCnt;
    @(negedge clk);
    start = 1'b1; dirWrite = isWrite;
    @(negedge clk);
    start = 1'b0;
    while (doneCnt == d0) @(negedge clk);
    repeat (2) @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic checkCs(int nEx, string req);
    int bad = 0;
    for (int j = 0; j < nEx - 1; j++) if (exCs[j] !== 1'b0) bad++;
    if (exCs[nEx - 1] !== 1'b1) bad++;
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic doRead(int k, bit expTmo);
    int nEx, bad;
    for (int i = 0; i < 64; i++) rxScript[i] = 8'hFF;
    for (int i = 0; i < k; i++) rxScript[i] = (i % 2) ? 8'h00 : 8'hFF;
    rxScript[k] = 8'hFE;
    if (!expTmo) begin
      for (int i = 0; i < PL; i++) rxScript[k + 1 + i] = rdPat(k, i);
      rxScript[k + 1 + PL] = 8'hA5;
      rxScript[k + 2 + PL] = 8'h5A;
    end
    runXfer(1'b0);
    nEx = expTmo ? HL + 1 : k + 1 + PL + 3;
    chk(exIdx == nEx, expTmo ? "R8 exchange count" : "R2 R4 exchange count", exIdx, nEx);
    bad = 0;
    for (int j = 0; j < nEx; j++) if (exTx[j] !== 8'hFF) bad++;
    chk(bad == 0, "R2 read sends only 0xFF", bad, 0);
    checkCs(nEx, "R9 read chip select pattern");
    chk(rdCnt == (expTmo ? 0 : PL), expTmo ? "R8 no delivery" : "R4 CRC not delivered", rdCnt, expTmo ? 0 : PL);
    if (!expTmo) begin
      bad = 0;
      for (int i = 0; i < PL; i++) if (rdLog[i] !== rdPat(k, i)) bad++;
      chk(bad == 0, "R3 read payload order", bad, 0);
    end
    chk(lastCode == (expTmo ? 2'd3 : 2'd0), expTmo ? "R8 timeout code" : "R10 ok code", lastCode, expTmo ? 3 : 0);
    chk(lastFail == expTmo, "R10 fail flag", lastFail, expTmo);
  endtask

  task automatic doWrite(int resp, int zeros);
    int nEx, bad, polls, expCode;
    bit acc;
    for (int i = 0; i < 64; i++) rxScript[i] = 8'hFF;
    rxScript[PL + 3] = 8'(resp);
    acc = ((resp & 31) == 5);
    if (acc) begin
      for (int z = 0; z < zeros; z++) rxScript[PL + 4 + z] = 8'h00;
      if (zeros < BL) rxScript[PL + 4 + zeros] = 8'h01;
    end
    polls = acc ? ((zeros >= BL) ? BL : zeros + 1) : 0;
    expCode = acc ? ((zeros >= BL) ? 3 : 0) : (((resp & 31) == 11) ? 1 : 2);
    wrSeed = resp + zeros * 7;
    runXfer(1'b1);
    nEx = PL + 4 + polls + 1;
    chk(exIdx == nEx, acc ? "R7 exchange count" : "R6 exchange count", exIdx, nEx);
    bad = 0;
    for (int j = 0; j < nEx; j++) begin
      if (j == 0) begin
        if (exTx[j] !== 8'hFE) bad++;
      end else if (j <= PL) begin
        if (exTx[j] !== wrPat(wrSeed, j - 1)) bad++;
      end else if (exTx[j] !== 8'hFF) bad++;
    end
    chk(bad == 0, "R5 write framing", bad, 0);
    checkCs(nEx, "R9 write chip select pattern");
    chk(lastCode == 2'(expCode), acc ? "R7 busy result code" : "R6 response code", lastCode, expCode);
    chk(lastFail == (expCode != 0), "R10 fail flag", lastFail, expCode != 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) rxScript[i] = 8'hFF;
    repeat (3) @(negedge clk);
    chk(csN === 1'b1 && spiReq === 1'b0, "R1 in reset cs/req", {csN, spiReq}, 2);
    rstN = 1'b1;
    @(negedge clk);
    chk(csN === 1'b1, "R1 csN after reset", csN, 1);
    chk(spiReq === 1'b0 && done === 1'b0, "R1 req/done after reset", {spiReq, done}, 0);
    chk(rdValid === 1'b0 && wrReady === 1'b0, "R1 streams after reset", {rdValid, wrReady}, 0);

    // R2 R3 R4: hunt length sweep up to the limit
    for (int k = 0; k < HL; k++) doRead(k, 1'b0);
    // R8: no start token within the limit
    doRead(HL, 1'b1);
    // R10: code held after done
    repeat (10) @(negedge clk);
    chk(errCode == 2'd3 && done == 1'b0, "R10 code held", errCode, 3);

    // R6: every response byte value
    for (int r = 0; r < 256; r++) doWrite(r, r % 4);
    // R7: busy length sweep up to and past the limit
    for (int z = 0; z <= BL; z++) doWrite(8'hE5, z);

    // R11: start during an active read is ignored
    begin
      int d0, bad;
      for (int i = 0; i < 64; i++) rxScript[i] = 8'hFF;
      rxScript[1] = 8'hFE;
      for (int i = 0; i < PL; i++) rxScript[2 + i] = rdPat(1, i);
      exIdx = 0; rdCnt = 0;
      d0 = doneCnt;
      @(negedge clk); start = 1'b1; dirWrite = 1'b0;
      @(negedge clk); start = 1'b0;
      repeat (6) @(negedge clk);
      start = 1'b1; dirWrite = 1'b1;
      @(negedge clk); start = 1'b0;
      while (doneCnt == d0) @(negedge clk);
      repeat (30) @(negedge clk);
      chk(doneCnt == d0 + 1, "R11 single done", doneCnt - d0, 1);
      chk(exIdx == 2 + PL + 3, "R11 exchange count", exIdx, 2 + PL + 3);
      bad = 0;
      for (int j = 0; j < exIdx; j++) if (exTx[j] !== 8'hFF) bad++;
      chk(bad == 0, "R11 no write framing", bad, 0);
      bad = 0;
      for (int i = 0; i < PL; i++) if (rdLog[i] !== rdPat(1, i)) bad++;
      chk(bad == 0 && rdCnt == PL, "R11 read data intact", bad, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule